// File: doc/BRIEF.md
# AHB-lite Address Decoder with Default Slave

This block sits between the single master of an AHB-lite system and up to eight slaves. It turns the address of each address phase into a one-hot slave select. Each slave owns a window of the memory map whose base and length are whole multiples of 1 KB, and both are set by parameters. Each slave also has an availability input, which is low while that slave is powered down or has its clock stopped. An unavailable slave is never selected.

An address that matches no available window goes to a default slave inside the block, so the bus cannot hang. The default slave gives idle and busy cycles a zero-wait OKAY response. It gives every real transfer a two-cycle ERROR response.

The block also returns read data, ready and response to the master. It chooses them from whichever slave owned the previous address phase. It holds that choice in a register that updates only while the bus is ready. Its own ready output is the bus ready, and it goes back out to every slave.

Top module: `ahb_region_decoder`

## Requirements
- R1: Slave i is selected (`hsel[i]` high) when `haddr[ADDR_W-1:10]` lies in [base_i, base_i + size_i), counted in 1 KB units, and `slv_avail[i]` is high. At most one `hsel` bit is high at a time.
- R2: When windows overlap, the lowest-numbered eligible slave wins.
- R3: A slave whose `slv_avail` bit is low is never selected. Its addresses go to the default slave.
- R4: An address matched by no window goes to the default slave, and all `hsel` bits are low.
- R5: The default slave answers IDLE (htrans 2'b00) and BUSY (2'b01) with `hready` high and `hresp` low (OKAY) in the data phase that follows.
- R6: The default slave answers NONSEQ (2'b10) and SEQ (2'b11) with two cycles. In the first, `hready` is low and `hresp` is high (ERROR). In the second, both are high. A real transfer sampled during that second cycle starts a new two-cycle error.
- R7: The data-phase select is captured only at an edge where `hready` is high. `hrdata`, `hready` and `hresp` follow the slave that owned the last captured address phase, including its wait states.
- R8: After reset the data-phase select points at the default slave, with `hready` high, `hresp` low and `hrdata` zero.
- R9: The default slave returns zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Synchronous active-low reset |
| haddr | input | ADDR_W | Address-phase address from the master |
| htrans | input | 2 | Transfer type (IDLE 0, BUSY 1, NONSEQ 2, SEQ 3) |
| slv_avail | input | NUM_SLV | High while slave i is powered and clocked |
| slv_hrdata | input | NUM_SLV*DATA_W | Read data from each slave, slave i at bits [i*DATA_W +: DATA_W] |
| slv_hreadyout | input | NUM_SLV | Ready output of each slave |
| slv_hresp | input | NUM_SLV | Response of each slave (1 = ERROR) |
| hsel | output | NUM_SLV | One-hot slave select for the address phase |
| hrdata | output | DATA_W | Read data returned to the master |
| hready | output | 1 | Bus ready, returned to the master and to all slaves |
| hresp | output | 1 | Response returned to the master (1 = ERROR) |

## Verification
The decoder is swept over every 1 KB step of the low 20 KB and over one high address. Each step is tried at two offsets, the first and the last word of the window, which catches off-by-one errors at window edges. Each address is tried with all 256 availability patterns. The default map has two overlapping windows, so this one sweep separates the priority rule from plain matching, and the gating by availability from the handling of unmapped addresses.

The return path is checked for each slave by giving every slave distinct read data. A stall is then held while the address moves to another slave, which shows whether the data-phase select updates without `hready`. On the default slave, the idle, busy, single-error and back-to-back error sequences each give a different ready/response pattern cycle by cycle.

// File: rtl/ahb_dec_pkg.sv
// Shared definitions for the AHB-lite decoder: transfer type codes,
// response codes and the default-slave state encoding.
package ahb_dec_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    localparam logic RESP_OKAY  = 1'b0;
    localparam logic RESP_ERROR = 1'b1;

    // Address bits below this index lie inside one 1 KB region unit.
    localparam int unsigned REGION_SHIFT = 10;

    typedef enum logic [1:0] {
        DS_READY    = 2'b00,
        DS_ERR_WAIT = 2'b01,
        DS_ERR_LAST = 2'b10
    } dflt_state_e;

    // True for transfers that carry data (NONSEQ or SEQ).
    function automatic logic is_real_xfer(input logic [1:0] tr);
        return (tr == TR_NONSEQ) || (tr == TR_SEQ);
    endfunction

endpackage

// File: rtl/ahb_region_match.sv
// Region matcher: compares the 1 KB unit index of the address with every
// slave window, masks off unavailable slaves and picks the lowest index.
// Assumes windows are given in 1 KB units and that base + size fits KB_W+1 bits.
module ahb_region_match #(
    parameter int unsigned NUM_SLV = 8,
    parameter int unsigned KB_W    = 22,
    parameter logic [NUM_SLV*KB_W-1:0] BASE_KB = '0,
    parameter logic [NUM_SLV*KB_W-1:0] SIZE_KB = '0
) (
    input  logic [KB_W-1:0]    addr_kb,
    input  logic [NUM_SLV-1:0] slv_avail,
    output logic [NUM_SLV-1:0] sel_onehot,
    output logic               sel_default
);

    logic [NUM_SLV-1:0] hit_raw;
    logic [NUM_SLV-1:0] eligible;

    // One window comparator per slave.
    for (genvar g = 0; g < NUM_SLV; g++) begin : g_win
        logic [KB_W:0] lo;
        logic [KB_W:0] hi;
        assign lo = {1'b0, BASE_KB[g*KB_W +: KB_W]};
        assign hi = lo + {1'b0, SIZE_KB[g*KB_W +: KB_W]};
        assign hit_raw[g] = ({1'b0, addr_kb} >= lo) && ({1'b0, addr_kb} < hi);
    end

    assign eligible = hit_raw & slv_avail;

    // Priority pick: lowest-index eligible slave owns the address.
    always_comb begin
        sel_onehot = '0;
        for (int i = NUM_SLV - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                sel_onehot    = '0;
                sel_onehot[i] = 1'b1;
            end
        end
    end

    assign sel_default = ~|eligible;

endmodule

// File: rtl/ahb_default_slave.sv
// Built-in default slave. Idle and busy cycles get a zero-wait OKAY;
// real transfers get a two-cycle ERROR (ready low, then ready high).
// Assumes hready is the bus ready returned to the master.
module ahb_default_slave
    import ahb_dec_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              hclk,
    input  logic              hresetn,
    input  logic              sel,
    input  logic [1:0]        htrans,
    input  logic              hready,
    output logic              readyout,
    output logic              resp,
    output logic [DATA_W-1:0] rdata
);

    dflt_state_e state_q, state_d;
    logic        take_real;

    assign take_real = hready && sel && is_real_xfer(htrans);

    // Next-state choice for the error sequence.
    always_comb begin
        state_d = DS_READY;
        case (state_q)
            DS_READY:    state_d = take_real ? DS_ERR_WAIT : DS_READY;
            DS_ERR_WAIT: state_d = DS_ERR_LAST;
            DS_ERR_LAST: state_d = take_real ? DS_ERR_WAIT : DS_READY;
            default:     state_d = DS_READY;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge hclk) begin
        if (!hresetn) state_q <= DS_READY;
        else          state_q <= state_d;
    end

    // Response outputs decoded from state.
    always_comb begin
        readyout = (state_q != DS_ERR_WAIT);
        resp     = (state_q == DS_READY) ? RESP_OKAY : RESP_ERROR;
    end

    assign rdata = '0;

    AST_ERR_FIRST: assert property (@(posedge hclk) disable iff (!hresetn)
        (hready && sel && is_real_xfer(htrans)) |=> (!readyout && resp)); // R6
    AST_ERR_SECOND: assert property (@(posedge hclk) disable iff (!hresetn)
        (!readyout) |=> (readyout && resp)); // R6
    AST_IDLE_OKAY: assert property (@(posedge hclk) disable iff (!hresetn)
        (hready && sel && !is_real_xfer(htrans)) |=> (readyout && !resp)); // R5

endmodule

// File: rtl/ahb_resp_mux.sv
// Data-phase return path: registers the one-hot owner of the address phase
// (bit NUM_SLV = default slave) while hready is high, and multiplexes read
// data, ready and response from that owner.
module ahb_resp_mux #(
    parameter int unsigned NUM_SLV = 8,
    parameter int unsigned DATA_W  = 32,
    localparam int unsigned NSEL   = NUM_SLV + 1
) (
    input  logic                      hclk,
    input  logic                      hresetn,
    input  logic                      hready,
    input  logic [NSEL-1:0]           addr_owner,
    input  logic [NUM_SLV*DATA_W-1:0] slv_hrdata,
    input  logic [NUM_SLV-1:0]        slv_hreadyout,
    input  logic [NUM_SLV-1:0]        slv_hresp,
    input  logic [DATA_W-1:0]         dflt_rdata,
    input  logic                      dflt_readyout,
    input  logic                      dflt_resp,
    output logic [DATA_W-1:0]         hrdata,
    output logic                      hreadyout,
    output logic                      hresp
);

    logic [NSEL-1:0] dsel_q;

    // Capture the address-phase owner only when the bus is ready.
    always_ff @(posedge hclk) begin
        if (!hresetn) begin
            dsel_q          <= '0;
            dsel_q[NUM_SLV] <= 1'b1;
        end else if (hready) begin
            dsel_q <= addr_owner;
        end
    end

    // AND-OR multiplexer over the one-hot data-phase select.
    always_comb begin
        hrdata    = dsel_q[NUM_SLV] ? dflt_rdata : '0;
        hreadyout = dsel_q[NUM_SLV] & dflt_readyout;
        hresp     = dsel_q[NUM_SLV] & dflt_resp;
        for (int i = 0; i < NUM_SLV; i++) begin
            if (dsel_q[i]) begin
                hrdata    = hrdata | slv_hrdata[i*DATA_W +: DATA_W];
                hreadyout = hreadyout | slv_hreadyout[i];
                hresp     = hresp | slv_hresp[i];
            end
        end
    end

    AST_DSEL_HOLD: assert property (@(posedge hclk) disable iff (!hresetn)
        (!hready) |=> $stable(dsel_q)); // R7
    AST_DSEL_ONEHOT: assert property (@(posedge hclk) disable iff (!hresetn)
        $onehot(dsel_q)); // R7

endmodule

// File: rtl/ahb_region_decoder.sv
// Top of the AHB-lite decoder: region match with availability gating,
// the built-in default slave and the data-phase return multiplexer.
// Assumes a single master and that bursts stay within one 1 KB unit.
module ahb_region_decoder
    import ahb_dec_pkg::*;
#(
    parameter int unsigned NUM_SLV = 8,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned DATA_W  = 32,
    localparam int unsigned KB_W   = ADDR_W - REGION_SHIFT,
    parameter logic [NUM_SLV*KB_W-1:0] BASE_KB =
        {22'd12, 22'd12, 22'd10, 22'd8, 22'd4, 22'd2, 22'd1, 22'd0},
    parameter logic [NUM_SLV*KB_W-1:0] SIZE_KB =
        {22'd4, 22'd1, 22'd2, 22'd1, 22'd4, 22'd2, 22'd1, 22'd1}
) (
    input  logic                      hclk,
    input  logic                      hresetn,
    input  logic [ADDR_W-1:0]         haddr,
    input  logic [1:0]                htrans,
    input  logic [NUM_SLV-1:0]        slv_avail,
    input  logic [NUM_SLV*DATA_W-1:0] slv_hrdata,
    input  logic [NUM_SLV-1:0]        slv_hreadyout,
    input  logic [NUM_SLV-1:0]        slv_hresp,
    output logic [NUM_SLV-1:0]        hsel,
    output logic [DATA_W-1:0]         hrdata,
    output logic                      hready,
    output logic                      hresp
);

    logic              sel_default;
    logic [9:0]        addr_low_unused;
    logic              dflt_readyout;
    logic              dflt_resp;
    logic [DATA_W-1:0] dflt_rdata;

    assign addr_low_unused = haddr[REGION_SHIFT-1:0];

    ahb_region_match #(
        .NUM_SLV (NUM_SLV),
        .KB_W    (KB_W),
        .BASE_KB (BASE_KB),
        .SIZE_KB (SIZE_KB)
    ) match_i (
        .addr_kb     (haddr[ADDR_W-1:REGION_SHIFT]),
        .slv_avail   (slv_avail),
        .sel_onehot  (hsel),
        .sel_default (sel_default)
    );

    ahb_default_slave #(
        .DATA_W (DATA_W)
    ) dflt_i (
        .hclk     (hclk),
        .hresetn  (hresetn),
        .sel      (sel_default),
        .htrans   (htrans),
        .hready   (hready),
        .readyout (dflt_readyout),
        .resp     (dflt_resp),
        .rdata    (dflt_rdata)
    );

    ahb_resp_mux #(
        .NUM_SLV (NUM_SLV),
        .DATA_W  (DATA_W)
    ) mux_i (
        .hclk          (hclk),
        .hresetn       (hresetn),
        .hready        (hready),
        .addr_owner    ({sel_default, hsel}),
        .slv_hrdata    (slv_hrdata),
        .slv_hreadyout (slv_hreadyout),
        .slv_hresp     (slv_hresp),
        .dflt_rdata    (dflt_rdata),
        .dflt_readyout (dflt_readyout),
        .dflt_resp     (dflt_resp),
        .hrdata        (hrdata),
        .hreadyout     (hready),
        .hresp         (hresp)
    );

    AST_SEL_ONEHOT: assert property (@(posedge hclk) disable iff (!hresetn)
        $onehot({sel_default, hsel})); // R1
    AST_SEL_AVAIL: assert property (@(posedge hclk) disable iff (!hresetn)
        (hsel & ~slv_avail) == '0); // R3

endmodule

// File: tb/ahb_region_decoder_tb.sv
`timescale 1ns/1ps
module ahb_region_decoder_tb_top;

    localparam int NS = 8;
    localparam int DW = 32;
    localparam int AW = 32;
    localparam int BASE [NS] = '{0, 1, 2, 4, 8, 10, 12, 12};
    localparam int SIZE [NS] = '{1, 1, 2, 4, 1, 2, 1, 4};

    logic           clk = 1'b0;
    logic           hresetn;
    logic [AW-1:0]  haddr;
    logic [1:0]     htrans;
    logic [NS-1:0]  slv_avail;
    logic [NS*DW-1:0] slv_hrdata;
    logic [NS-1:0]  slv_hreadyout;
    logic [NS-1:0]  slv_hresp;
    logic [NS-1:0]  hsel;
    logic [DW-1:0]  hrdata;
    logic           hready;
    logic           hresp;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ahb_region_decoder dut_i (
        .hclk (clk), .hresetn (hresetn), .haddr (haddr), .htrans (htrans),
        .slv_avail (slv_avail), .slv_hrdata (slv_hrdata),
        .slv_hreadyout (slv_hreadyout), .slv_hresp (slv_hresp),
        .hsel (hsel), .hrdata (hrdata), .hready (hready), .hresp (hresp)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [NS-1:0] exp_sel(input int kb, input logic [NS-1:0] av);
        for (int i = 0; i < NS; i++)
            if (av[i] && kb >= BASE[i] && kb < BASE[i] + SIZE[i]) return NS'(1) << i;
        return '0;
    endfunction

    function automatic logic [DW-1:0] pat(input int i);
        return 32'hC0DE_0000 + 32'(i * 32'h111);
    endfunction

    task automatic chk_ret(input string req, input logic rdy, input logic rsp,
                           input logic [DW-1:0] dat);
        chk(hready == rdy, req, 64'(hready), 64'(rdy));
        chk(hresp == rsp, req, 64'(hresp), 64'(rsp));
        chk(hrdata == dat, req, 64'(hrdata), 64'(dat));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        hresetn = 1'b0; haddr = '0; htrans = 2'b00; slv_avail = '1;
        slv_hreadyout = '1; slv_hresp = '0;
        for (int i = 0; i < NS; i++) slv_hrdata[i*DW +: DW] = pat(i);
        repeat (20) @(posedge clk);
        #1;
        chk_ret("R8 reset state", 1'b1, 1'b0, '0);
        @(negedge clk); hresetn = 1'b1;

        // R1 R2 R3 R4: address x availability sweep
        for (int kb = 0; kb <= 20; kb++) begin
            for (int off = 0; off < 2; off++) begin
                for (int av = 0; av < 256; av++) begin
                    int k;
                    k = (kb == 20) ? 32'h3F_FFFF : kb;
                    haddr = AW'(k) * 1024 + (off != 0 ? 32'h3FC : 32'h0);
                    slv_avail = NS'(av);
                    #0.01;
                    chk(hsel == exp_sel(k, NS'(av)), "R1 R2 R3 R4 decode",
                        64'(hsel), 64'(exp_sel(k, NS'(av))));
                end
            end
        end
        slv_avail = '1; haddr = '0;

        // R7: each slave's data reaches the master
        for (int s = 0; s < NS; s++) begin
            @(negedge clk);
            haddr = AW'((s == 7) ? 13 : BASE[s]) * 1024; htrans = 2'b10;
            @(negedge clk);
            chk_ret("R7 return path", 1'b1, 1'b0, pat(s));
            htrans = 2'b00;
        end

        // R7: stall holds the data-phase owner
        @(negedge clk); haddr = 32'd4 * 1024; htrans = 2'b10;
        @(negedge clk);
        slv_hreadyout[3] = 1'b0; slv_hresp[3] = 1'b1;
        haddr = 32'd10 * 1024;
        #0.5;
        chk_ret("R7 wait state", 1'b0, 1'b1, pat(3));
        @(negedge clk);
        chk_ret("R7 owner held in stall", 1'b0, 1'b1, pat(3));
        slv_hreadyout[3] = 1'b1; slv_hresp[3] = 1'b0;
        @(negedge clk);
        chk_ret("R7 capture after stall", 1'b1, 1'b0, pat(5));
        htrans = 2'b00;

        // R6 R9: real transfer to unmapped address
        @(negedge clk); haddr = 32'd9 * 1024; htrans = 2'b10;
        @(negedge clk);
        chk_ret("R6 R9 error first", 1'b0, 1'b1, '0);
        @(negedge clk);
        chk_ret("R6 error second", 1'b1, 1'b1, '0);
        htrans = 2'b00;
        @(negedge clk);
        chk_ret("R5 idle okay", 1'b1, 1'b0, '0);
        htrans = 2'b01;
        @(negedge clk);
        chk_ret("R5 busy okay", 1'b1, 1'b0, '0);

        // R3 R6: unavailable slave, back-to-back errors
        slv_avail[2] = 1'b0; haddr = 32'd2 * 1024; htrans = 2'b11;
        #0.5;
        chk(hsel == '0, "R3 unavailable not selected", 64'(hsel), 64'h0);
        @(negedge clk);
        chk_ret("R3 R6 error first", 1'b0, 1'b1, '0);
        @(negedge clk);
        chk_ret("R6 error second", 1'b1, 1'b1, '0);
        @(negedge clk);
        chk_ret("R6 back-to-back error", 1'b0, 1'b1, '0);
        htrans = 2'b00;
        @(negedge clk);
        chk_ret("R6 error second again", 1'b1, 1'b1, '0);
        @(negedge clk);
        chk_ret("R5 okay after error", 1'b1, 1'b0, '0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule